// File: doc/BRIEF.md
# SPI Slave Mailbox Register Interface

This block is an SPI slave that gives an external host access to a small bank of byte-wide registers. Every transaction is a 16-bit frame. Bit 15 selects the direction: 1 is a write, 0 is a read request. A write is a single frame carrying a 5-bit address and a data byte. A read takes two frames. The first frame names the register. The value is captured when that frame ends and is shifted back to the host during the following 16-bit frame. The block samples the SPI pins with the system clock, so SCLK must be well below the system clock rate.

A local microcontroller port sits on the other side of the bank. Through it the local side fills the host mailboxes. Each write to a host mailbox sets a pending flag for that mailbox, and the host interrupt output is the OR of all pending flags. The host clears a flag by reading that mailbox. Two groups of scratch registers have the same access pattern but never raise the interrupt. Host scratch registers are written by the host and read locally. Local scratch registers are written locally and read by the host.

Top module: `spi_mbx_top`

## Requirements
- R1: Address map, shared by the host and the local port: host mailboxes at 00h–03h, host scratch at 04h–07h, local scratch at 08h–0Bh. A host write frame (bit 15 = 1, address in bits 14:10, data in bits 7:0) to 04h–07h stores the data byte in that host scratch register.
- R2: A host read frame (bit 15 = 0, address in bits 14:10) captures the addressed value at the end of that frame. During the next 16-bit frame MISO returns {8'h00, value}, MSB first. In SPI mode 0, MOSI is sampled on the rising SCLK edge and MISO changes after the falling edge.
- R3: A local write to a host mailbox (00h–03h) sets that mailbox's pending flag. host_irq is high from the next clock.
- R4: host_irq is the OR of the four pending flags. A flag stays set until the end of a host read frame that addresses its own mailbox. A read of a different mailbox leaves it set.
- R5: Writes to scratch registers, from either side, never set host_irq.
- R6: Host write frames to mailbox addresses (00h–03h) and local scratch addresses (08h–0Bh) are dropped.
- R7: Host writes to 0Ch–1Fh change no register. Host reads of those addresses return 00h. An address is never folded onto a lower register.
- R8: Reserved bits are ignored on input: bits 9:8 of a write frame and bits 9:0 of a read frame.
- R9: Raising CS_N before the 16th rising SCLK edge discards the partial frame with no register change. The next frame is decoded from its first bit.
- R10: If a local mailbox write lands in the same clock as the end of a host read frame for that mailbox, the read returns the old value and the pending flag stays set.
- R11: loc_rdata combinationally returns the register at loc_addr (00h–0Bh), and 00h elsewhere. Local writes to host scratch (04h–07h) are ignored.
- R12: After reset all registers are 00h, host_irq is low and spi_miso is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, low while deselected |
| loc_wr | input | 1 | Local register write strobe |
| loc_addr | input | 5 | Local register address |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data, combinational |
| host_irq | output | 1 | Host interrupt, OR of mailbox pending flags |

## Verification
A local write to a mailbox and the end of a host read frame for the same mailbox can fall in the same clock. In that clock, one path sets the pending flag and the other clears it, while the read captures the value. The bench aligns a local write strobe with the exact clock in which the 16th rising SCLK edge passes the synchronizer. It then checks three things: the data frame carries the value from before the write, host_irq stays high, and a second read returns the new value and clears the flag.

// File: rtl/spi_mbx_pkg.sv
package spi_mbx_pkg;

    // Frame geometry
    localparam int FRAME_W  = 16;
    localparam int CNT_W    = $clog2(FRAME_W);
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 8;
    localparam int CMD_BIT  = FRAME_W - 1;
    localparam int ADDR_LSB = CMD_BIT - ADDR_W;

    // Register bank geometry; bases are multiples of the slot count
    localparam int NUM_MBX = 4;
    localparam int NUM_SCR = 4;
    localparam int SLOT_W  = $clog2(NUM_MBX);

    typedef logic [DATA_W-1:0]  byte_t;
    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [SLOT_W-1:0]  slot_t;

    localparam addr_t LAST_ADDR = 5'h1A;
    localparam addr_t MBX_BASE  = '0;
    localparam addr_t HSCR_BASE = addr_t'(NUM_MBX);
    localparam addr_t LSCR_BASE = addr_t'(NUM_MBX + NUM_SCR);
    localparam addr_t MAP_END   = addr_t'(NUM_MBX + 2 * NUM_SCR);

    typedef enum logic [1:0] {
        RG_NONE,
        RG_MBX,
        RG_HSCR,
        RG_LSCR
    } region_e;

    // Decoded host request; reserved frame bits are not carried
    typedef struct packed {
        logic  is_write;
        addr_t addr;
        byte_t data;
    } req_t;

    function automatic region_e region_of(addr_t a);
        region_e r;
        if (a > LAST_ADDR || a >= MAP_END) r = RG_NONE;
        else if (a >= LSCR_BASE)           r = RG_LSCR;
        else if (a >= HSCR_BASE)           r = RG_HSCR;
        else                               r = RG_MBX;
        return r;
    endfunction

    function automatic slot_t slot_of(addr_t a);
        return a[SLOT_W-1:0];
    endfunction

    function automatic req_t unpack_frame(frame_t f);
        req_t r;
        r.is_write = f[CMD_BIT];
        r.addr     = f[ADDR_LSB +: ADDR_W];
        r.data     = f[DATA_W-1:0];
        return r;
    endfunction

    function automatic frame_t reply_frame(byte_t v);
        return frame_t'(v);
    endfunction

endpackage

// File: rtl/spi_mbx_sync.sv
module spi_mbx_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage[s] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/spi_mbx_frame.sv
module spi_mbx_frame
    import spi_mbx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_s,
    input  logic   cs_act,
    input  logic   mosi_s,
    input  logic   load_en,
    input  frame_t load_word,
    output logic   frame_vld,
    output frame_t frame_word,
    output logic   miso
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    logic               sclk_d;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-2:0] rx_sh;
    frame_t             tx_sh;
    frame_t             tx_hold;
    logic               rise;
    logic               fall;

    assign rise       = sclk_s & ~sclk_d;
    assign fall       = ~sclk_s & sclk_d;
    assign frame_vld  = cs_act & rise & (bit_cnt == LAST_BIT);
    assign frame_word = {rx_sh, mosi_s};
    assign miso       = cs_act & tx_sh[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            tx_hold <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (!cs_act) begin
                // deselect drops any partial frame and rewinds the reply
                bit_cnt <= '0;
                tx_sh   <= tx_hold;
            end else begin
                if (rise) begin
                    rx_sh   <= {rx_sh[FRAME_W-3:0], mosi_s};
                    bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
                end
                if (load_en) begin
                    tx_sh   <= load_word;
                    tx_hold <= load_word;
                end else if (fall && bit_cnt != '0) begin
                    tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/spi_mbx_regs.sv
module spi_mbx_regs
    import spi_mbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  host_wr,
    input  logic  host_rd,
    input  addr_t host_addr,
    input  byte_t host_wdata,
    output byte_t host_rdata,
    input  logic  loc_wr,
    input  addr_t loc_addr,
    input  byte_t loc_wdata,
    output byte_t loc_rdata,
    output logic  irq
);

    byte_t mbx  [NUM_MBX];
    byte_t hscr [NUM_SCR];
    byte_t lscr [NUM_SCR];
    logic [NUM_MBX-1:0] pend;

    region_e host_rg;
    region_e loc_rg;
    slot_t   host_slot;
    slot_t   loc_slot;

    assign host_rg   = region_of(host_addr);
    assign loc_rg    = region_of(loc_addr);
    assign host_slot = slot_of(host_addr);
    assign loc_slot  = slot_of(loc_addr);

    generate
        for (genvar i = 0; i < NUM_MBX; i++) begin : g_mbx
            logic loc_hit;
            logic host_hit;
            assign loc_hit  = loc_wr && loc_rg == RG_MBX && loc_slot == slot_t'(i);
            assign host_hit = host_rd && host_rg == RG_MBX && host_slot == slot_t'(i);

            always_ff @(posedge clk) begin
                if (rst) begin
                    mbx[i]  <= '0;
                    pend[i] <= 1'b0;
                end else begin
                    if (loc_hit) mbx[i] <= loc_wdata;
                    // a fresh local write outranks a clearing host read
                    if (loc_hit)       pend[i] <= 1'b1;
                    else if (host_hit) pend[i] <= 1'b0;
                end
            end
        end

        for (genvar j = 0; j < NUM_SCR; j++) begin : g_scr
            always_ff @(posedge clk) begin
                if (rst) begin
                    hscr[j] <= '0;
                    lscr[j] <= '0;
                end else begin
                    if (host_wr && host_rg == RG_HSCR && host_slot == slot_t'(j))
                        hscr[j] <= host_wdata;
                    if (loc_wr && loc_rg == RG_LSCR && loc_slot == slot_t'(j))
                        lscr[j] <= loc_wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        unique case (host_rg)
            RG_MBX:  host_rdata = mbx[host_slot];
            RG_HSCR: host_rdata = hscr[host_slot];
            RG_LSCR: host_rdata = lscr[host_slot];
            default: host_rdata = '0;
        endcase
    end

    always_comb begin
        unique case (loc_rg)
            RG_MBX:  loc_rdata = mbx[loc_slot];
            RG_HSCR: loc_rdata = hscr[loc_slot];
            RG_LSCR: loc_rdata = lscr[loc_slot];
            default: loc_rdata = '0;
        endcase
    end

    assign irq = |pend;

endmodule

// File: rtl/spi_mbx_top.sv
module spi_mbx_top
    import spi_mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              loc_wr,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] loc_rdata,
    output logic              host_irq
);

    logic [2:0] pins_s;
    logic       sclk_s;
    logic       cs_n_s;
    logic       mosi_s;
    logic       frame_vld;
    frame_t     frame_word;
    req_t       req;
    byte_t      host_rdata;
    frame_t     reply;

    spi_mbx_sync #(
        .WIDTH   (3),
        .STAGES  (2),
        .RST_VAL (3'b010)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_sclk, spi_cs_n, spi_mosi}),
        .q   (pins_s)
    );

    assign {sclk_s, cs_n_s, mosi_s} = pins_s;

    assign req   = unpack_frame(frame_word);
    assign reply = req.is_write ? '0 : reply_frame(host_rdata);

    spi_mbx_frame i_frame (
        .clk        (clk),
        .rst        (rst),
        .sclk_s     (sclk_s),
        .cs_act     (~cs_n_s),
        .mosi_s     (mosi_s),
        .load_en    (frame_vld),
        .load_word  (reply),
        .frame_vld  (frame_vld),
        .frame_word (frame_word),
        .miso       (spi_miso)
    );

    spi_mbx_regs i_regs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (frame_vld & req.is_write),
        .host_rd    (frame_vld & ~req.is_write),
        .host_addr  (req.addr),
        .host_wdata (req.data),
        .host_rdata (host_rdata),
        .loc_wr     (loc_wr),
        .loc_addr   (loc_addr),
        .loc_wdata  (loc_wdata),
        .loc_rdata  (loc_rdata),
        .irq        (host_irq)
    );

endmodule

// File: rtl/spi_mbx_checker.sv
module spi_mbx_checker
    import spi_mbx_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  spi_cs_n,
    input logic  spi_miso,
    input logic  host_irq,
    input logic  loc_wr,
    input addr_t loc_addr,
    input logic  frame_vld,
    input logic  frame_is_write
);

    // R12: reset leaves the interrupt low
    a_r12_reset_quiet: assert property (@(posedge clk)
        rst |=> !host_irq);

    // R3: local mailbox write raises the interrupt on the next clock
    a_r3_irq_on_mbx_write: assert property (@(posedge clk) disable iff (rst)
        (loc_wr && loc_addr < HSCR_BASE) |=> host_irq);

    // R5: scratch writes never raise the interrupt
    a_r5_scratch_quiet: assert property (@(posedge clk) disable iff (rst)
        (!host_irq && (!loc_wr || loc_addr >= HSCR_BASE)) |=> !host_irq);

    // R4: the interrupt holds while no host frame completes
    a_r4_irq_hold: assert property (@(posedge clk) disable iff (rst)
        (host_irq && !frame_vld) |=> host_irq);

    // R2: the reply frame starts with a reserved zero bit
    a_r2_reply_msb_zero: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && !frame_is_write) |=> !spi_miso);

    // R9: a settled deselect means no frame and a quiet MISO
    a_r9_idle_when_deselected: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> (!spi_miso && !frame_vld));

endmodule

bind spi_mbx_top spi_mbx_checker i_chk (
    .clk            (clk),
    .rst            (rst),
    .spi_cs_n       (spi_cs_n),
    .spi_miso       (spi_miso),
    .host_irq       (host_irq),
    .loc_wr         (loc_wr),
    .loc_addr       (loc_addr),
    .frame_vld      (frame_vld),
    .frame_is_write (req.is_write)
);

// File: tb/test_spi_mbx_top.sv
module test_spi_mbx_top;

    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       loc_wr = 1'b0;
    logic [4:0] loc_addr = '0;
    logic [7:0] loc_wdata = '0;
    logic [7:0] loc_rdata;
    logic       host_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    spi_mbx_top i_spi_mbx_top (
        .clk       (clk),
        .rst       (rst),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .loc_wr    (loc_wr),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata),
        .loc_rdata (loc_rdata),
        .host_irq  (host_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One SPI frame; cut < 16 aborts early, coll fires a local write at the frame end
    task automatic spi_frame(input logic [15:0] txw, output logic [15:0] rxw, input int cut,
                             input bit coll, input logic [4:0] caddr, input logic [7:0] cdata);
        rxw = '0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_n(HALF);
        for (int i = 15; i >= 0; i--) begin
            if (15 - i >= cut) break;
            spi_mosi = txw[i];
            wait_n(HALF);
            rxw[i] = spi_miso;
            spi_sclk = 1'b1;
            if (i == 0 && coll) begin
                wait_n(2);
                loc_wr = 1'b1; loc_addr = caddr; loc_wdata = cdata;
                wait_n(1);
                loc_wr = 1'b0;
                wait_n(HALF - 3);
            end else begin
                wait_n(HALF);
            end
            spi_sclk = 1'b0;
        end
        wait_n(HALF);
        spi_cs_n = 1'b1;
        wait_n(HALF);
    endtask

    task automatic host_write(input logic [4:0] a, input logic [7:0] d, input logic [1:0] rsv);
        logic [15:0] rx;
        spi_frame({1'b1, a, rsv, d}, rx, 16, 1'b0, '0, '0);
    endtask

    task automatic host_read(input logic [4:0] a, input logic [9:0] rsv, output logic [7:0] d);
        logic [15:0] rx;
        spi_frame({1'b0, a, rsv}, rx, 16, 1'b0, '0, '0);
        spi_frame(16'h0000, rx, 16, 1'b0, '0, '0);
        chk("R2 reserved reply byte", {24'h0, rx[15:8]}, 32'h0);
        d = rx[7:0];
    endtask

    task automatic loc_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        loc_wr = 1'b1; loc_addr = a; loc_wdata = d;
        @(negedge clk);
        loc_wr = 1'b0;
    endtask

    function automatic logic [31:0] w8(input logic [7:0] v);
        return {24'h0, v};
    endfunction

    task automatic loc_peek(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        loc_addr = a;
        #1 d = loc_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R12 irq after reset", {31'h0, host_irq}, 32'h0);
        chk("R12 miso after reset", {31'h0, spi_miso}, 32'h0);
        loc_peek(5'h00, d); chk("R12 mailbox0 reset", w8(d), 32'h0);
        loc_peek(5'h06, d); chk("R12 host scratch reset", w8(d), 32'h0);
        loc_peek(5'h0B, d); chk("R12 local scratch reset", w8(d), 32'h0);
    endtask

    task automatic t_host_scratch;
        logic [7:0] d;
        host_write(5'h05, 8'hA5, 2'b11);
        loc_peek(5'h05, d); chk("R1 R8 host scratch write", w8(d), 32'hA5);
        host_write(5'h07, 8'h3C, 2'b00);
        host_read(5'h07, 10'h000, d); chk("R2 host scratch read", w8(d), 32'h3C);
        host_read(5'h05, 10'h3FF, d); chk("R8 read with reserved bits", w8(d), 32'hA5);
        chk("R5 host scratch no irq", {31'h0, host_irq}, 32'h0);
    endtask

    task automatic t_dropped;
        logic [7:0] d;
        host_write(5'h01, 8'h77, 2'b00);
        loc_peek(5'h01, d); chk("R6 host write to mailbox dropped", w8(d), 32'h0);
        host_write(5'h09, 8'h66, 2'b00);
        loc_peek(5'h09, d); chk("R6 host write to local scratch dropped", w8(d), 32'h0);
        chk("R6 no irq from dropped write", {31'h0, host_irq}, 32'h0);
    endtask

    task automatic t_bad_addr;
        logic [7:0] d;
        host_write(5'h1C, 8'h33, 2'b00);
        loc_peek(5'h04, d); chk("R7 write 1Ch not folded", w8(d), 32'h0);
        host_write(5'h10, 8'h44, 2'b00);
        host_read(5'h10, 10'h000, d); chk("R7 read 10h", w8(d), 32'h0);
        host_read(5'h1B, 10'h000, d); chk("R7 read 1Bh", w8(d), 32'h0);
    endtask

    task automatic t_local;
        logic [7:0] d;
        loc_write(5'h0A, 8'h5A);
        @(negedge clk); chk("R5 local scratch no irq", {31'h0, host_irq}, 32'h0);
        host_read(5'h0A, 10'h000, d); chk("R11 local scratch to host", w8(d), 32'h5A);
        loc_write(5'h05, 8'hFF);
        loc_peek(5'h05, d); chk("R11 local write to host scratch ignored", w8(d), 32'hA5);
        loc_peek(5'h14, d); chk("R11 local read unmapped", w8(d), 32'h0);
    endtask

    task automatic t_mailbox;
        logic [7:0] d;
        loc_write(5'h02, 8'hC3);
        chk("R3 irq after mailbox write", {31'h0, host_irq}, 32'h1);
        host_read(5'h00, 10'h000, d);
        chk("R4 irq held over other read", {31'h0, host_irq}, 32'h1);
        host_read(5'h02, 10'h000, d);
        chk("R2 mailbox2 data", w8(d), 32'hC3);
        chk("R4 irq cleared by own read", {31'h0, host_irq}, 32'h0);
        loc_write(5'h00, 8'h10);
        loc_write(5'h03, 8'h13);
        host_read(5'h00, 10'h000, d);
        chk("R4 irq held by mailbox3", {31'h0, host_irq}, 32'h1);
        host_read(5'h03, 10'h000, d);
        chk("R2 mailbox3 data", w8(d), 32'h13);
        chk("R4 irq cleared after both", {31'h0, host_irq}, 32'h0);
    endtask

    task automatic t_partial;
        logic [7:0]  d;
        logic [15:0] rx;
        spi_frame({1'b1, 5'h06, 2'b00, 8'h99}, rx, 9, 1'b0, '0, '0);
        loc_peek(5'h06, d); chk("R9 partial frame discarded", w8(d), 32'h0);
        host_write(5'h06, 8'h12, 2'b00);
        host_read(5'h06, 10'h000, d); chk("R9 next frame decoded", w8(d), 32'h12);
    endtask

    task automatic t_collision;
        logic [7:0]  d;
        logic [15:0] rx;
        loc_write(5'h01, 8'h11);
        spi_frame({1'b0, 5'h01, 10'h000}, rx, 16, 1'b1, 5'h01, 8'h22);
        spi_frame(16'h0000, rx, 16, 1'b0, '0, '0);
        chk("R10 read returns old value", {16'h0, rx}, 32'h0011);
        chk("R10 flag survives collision", {31'h0, host_irq}, 32'h1);
        host_read(5'h01, 10'h000, d);
        chk("R10 second read new value", w8(d), 32'h22);
        chk("R10 flag cleared afterwards", {31'h0, host_irq}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        wait_n(2);
        t_reset();
        t_host_scratch();
        t_dropped();
        t_bad_addr();
        t_local();
        t_mailbox();
        t_partial();
        t_collision();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule